// File: doc/BRIEF.md
# Privilege and Window-Mapping Unit

This unit sits between the address generation of a small stack processor and its 64 KB memory. It derives the privilege level from where the program counter currently points: code fetched from the bottom 4 KB is the supervisor, and everything else runs as a user process. Supervisor accesses reach memory with their addresses unchanged. A user process sees a single 4 KB window at logical addresses 0x0000–0x0FFF. A page register, which only the supervisor may load, moves that window to any 4 KB block of physical memory.

The unit also holds the fixed upper parts of the two stack pointers. These parts are not counted: 8 bits for the data stack and 12 bits for the return stack. Only the supervisor may load them. A user attempt to touch memory outside its window, to load a stack pointer or to load the page register is refused. In the same cycle the memory write enable is forced low. On the following clock edge a one-cycle fault request is raised for the interrupt logic.

Top module: `win_guard_unit`

## Requirements
- R1: When `pc_i` < 0x1000 the access is privileged: `phys_addr_o` equals `mem_addr_i` and `access_ok_o` follows `mem_req_i` for every address.
- R2: When `pc_i` >= 0x1000 and `mem_addr_i` < 0x1000, `phys_addr_o` is {page register (4 bits), `mem_addr_i[11:0]`} and `access_ok_o` is 1 in the same cycle.
- R3: A user access with `mem_addr_i` >= 0x1000 gives `access_ok_o` = 0 and `mem_we_o` = 0 in the same cycle, and `fault_o` = 1 in the next cycle.
- R4: A privileged `pg_wr_i` loads `pg_data_i` into the page register. The new value translates user accesses from the next cycle on.
- R5: A user `pg_wr_i` leaves the page register unchanged and raises `fault_o` in the next cycle.
- R6: A privileged `sp_wr_i` loads the stack upper part on the next edge. With `sp_sel_i` = 0 (data stack), `dsp_hi_o` takes `sp_data_i[15:8]`. With `sp_sel_i` = 1 (return stack), `rsp_hi_o` takes `sp_data_i[15:4]`.
- R7: A user `sp_wr_i` changes neither `dsp_hi_o` nor `rsp_hi_o` and raises `fault_o` in the next cycle.
- R8: While `rst_n` is low and after its release, `fault_o` is 0, both stack upper parts are 0 and the page register is 0.
- R9: `fault_o` is 1 in a cycle exactly when the previous cycle held a violation (R3, R5 or R7). Each violating cycle therefore produces one cycle of fault, and a cycle with no violation is followed by `fault_o` = 0.
- R10: `mem_we_o` is 1 only when `mem_req_i`, `mem_we_i` and `access_ok_o` are all 1. With no request, `access_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 16 | Address of the instruction now executing |
| mem_req_i | input | 1 | A memory access is made this cycle |
| mem_we_i | input | 1 | The access is a write |
| mem_addr_i | input | 16 | Logical address of the access |
| sp_wr_i | input | 1 | Request to load a stack pointer upper part |
| sp_sel_i | input | 1 | 0 selects the data stack, 1 the return stack |
| sp_data_i | input | 16 | Full stack pointer value offered for loading |
| pg_wr_i | input | 1 | Request to load the page register |
| pg_data_i | input | 4 | New physical block number for the user window |
| phys_addr_o | output | 16 | Translated physical address |
| mem_we_o | output | 1 | Write enable to memory, gated by the check |
| access_ok_o | output | 1 | The current request is allowed |
| fault_o | output | 1 | One-cycle protection fault interrupt request |
| dsp_hi_o | output | 8 | Fixed upper part of the data stack pointer |
| rsp_hi_o | output | 12 | Fixed upper part of the return stack pointer |

## Verification
On every cycle the assertions check the following. The write enable never passes a refused access. Each fault can be traced to a violation in the previous cycle. Supervisor addresses pass through unchanged. The 12-bit offset always survives translation. A user stack-pointer load leaves both upper parts stable. The effect of the page register, which has no port, can only be seen through the bench's scenarios: a supervisor load, a refused user load, and the boundary program counter values 0x0FFF and 0x1000 followed by translated accesses. The same holds for back-to-back violations giving back-to-back fault cycles, and for the values held through reset.

// File: rtl/win_guard_pkg.sv
// Shared types for the privilege and window-mapping unit.
// Assumes: one violation vector per cycle, one bit per refusal cause.
package win_guard_pkg;

    // Causes of a protection refusal seen in a single cycle
    typedef struct packed {
        logic mem_out;   // user access outside its window
        logic stk_wr;    // user stack pointer load
        logic page_wr;   // user page register load
    } viol_t;

    // Which stack an upper-part load targets
    typedef enum logic {
        STK_DATA = 1'b0,
        STK_RET  = 1'b1
    } stk_sel_e;

endpackage

// File: rtl/wg_priv_decode.sv
// Privilege decode: the supervisor is whatever executes in the lowest window.
// Assumes: the window size is a power of two, 2**WIN_W bytes.
module wg_priv_decode #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 12
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic              priv_o
);
    localparam int TOP_W = ADDR_W - WIN_W;

    // Privileged when no bit above the window offset is set
    always_comb begin
        priv_o = (pc_i[ADDR_W-1:WIN_W] == {TOP_W{1'b0}});
    end
endmodule

// File: rtl/wg_page_map.sv
// Page register and address translation for the single user window.
// Assumes: privileged code sees memory flat. User logical addresses below
// 2**WIN_W are relocated to the block held in the page register.
module wg_page_map #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     priv_i,
    input  logic                     pg_wr_i,
    input  logic [ADDR_W-WIN_W-1:0]  pg_data_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [ADDR_W-1:0]        phys_o,
    output logic                     in_win_o
);
    localparam int PG_W = ADDR_W - WIN_W;

    logic [PG_W-1:0] page_q;

    // Page register: loaded only by privileged code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (pg_wr_i && priv_i) begin
            page_q <= pg_data_i;
        end
    end

    // Window membership of the logical address
    always_comb begin
        in_win_o = (addr_i[ADDR_W-1:WIN_W] == {PG_W{1'b0}});
    end

    // Translation: flat for the supervisor, relocated for the user
    always_comb begin
        if (priv_i) begin
            phys_o = addr_i;
        end else begin
            phys_o = {page_q, addr_i[WIN_W-1:0]};
        end
    end
endmodule

// File: rtl/wg_fault_gen.sv
// Protection check: refuses user violations in the cycle they occur and
// registers a one-cycle fault request for the interrupt logic.
// Assumes: all request inputs are valid for the whole cycle.
module wg_fault_gen
    import win_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic priv_i,
    input  logic mem_req_i,
    input  logic mem_we_i,
    input  logic in_win_i,
    input  logic sp_wr_i,
    input  logic pg_wr_i,
    output logic access_ok_o,
    output logic mem_we_o,
    output logic stk_wr_ok_o,
    output logic fault_o
);
    viol_t viol;
    logic  fault_q;

    // Collect the refusal causes of this cycle
    always_comb begin
        viol.mem_out = !priv_i && mem_req_i && !in_win_i;
        viol.stk_wr  = !priv_i && sp_wr_i;
        viol.page_wr = !priv_i && pg_wr_i;
    end

    // Grant or gate the memory side in the same cycle
    always_comb begin
        access_ok_o = mem_req_i && !viol.mem_out;
        mem_we_o    = access_ok_o && mem_we_i;
        stk_wr_ok_o = sp_wr_i && priv_i;
    end

    // Fault request: high for the cycle after each violating cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= |viol;
        end
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/wg_stack_hi.sv
// Holds the fixed (not counted) upper part of one stack pointer.
// Assumes: the offered value is a full pointer; its top HI_W bits are kept.
module wg_stack_hi #(
    parameter int ADDR_W = 16,
    parameter int HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] data_i,
    output logic [HI_W-1:0]   hi_o
);
    logic [HI_W-1:0] hi_q;

    // Upper part register, loaded on an allowed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (wr_i) begin
            hi_q <= data_i[ADDR_W-1 -: HI_W];
        end
    end

    assign hi_o = hi_q;
endmodule

// File: rtl/win_guard_unit.sv
// Privilege and window-mapping unit for a small stack processor.
// Privilege comes only from the program counter lying in the lowest window.
// User code gets one relocatable window and may not load the stack pointer
// upper parts or the page register.
// Assumes: one access per cycle. Faults go to an external interrupt controller.
module win_guard_unit
    import win_guard_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_W    = 12,
    parameter int DSP_HI_W = 8,
    parameter int RSP_HI_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       pc_i,
    input  logic                    mem_req_i,
    input  logic                    mem_we_i,
    input  logic [ADDR_W-1:0]       mem_addr_i,
    input  logic                    sp_wr_i,
    input  logic                    sp_sel_i,
    input  logic [ADDR_W-1:0]       sp_data_i,
    input  logic                    pg_wr_i,
    input  logic [ADDR_W-WIN_W-1:0] pg_data_i,
    output logic [ADDR_W-1:0]       phys_addr_o,
    output logic                    mem_we_o,
    output logic                    access_ok_o,
    output logic                    fault_o,
    output logic [DSP_HI_W-1:0]     dsp_hi_o,
    output logic [RSP_HI_W-1:0]     rsp_hi_o
);
    logic priv;
    logic in_win;
    logic stk_wr_ok;
    logic dsp_wr;
    logic rsp_wr;

    wg_priv_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) i_priv (
        .pc_i   (pc_i),
        .priv_o (priv)
    );

    wg_page_map #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) i_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .priv_i    (priv),
        .pg_wr_i   (pg_wr_i),
        .pg_data_i (pg_data_i),
        .addr_i    (mem_addr_i),
        .phys_o    (phys_addr_o),
        .in_win_o  (in_win)
    );

    wg_fault_gen i_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_i      (priv),
        .mem_req_i   (mem_req_i),
        .mem_we_i    (mem_we_i),
        .in_win_i    (in_win),
        .sp_wr_i     (sp_wr_i),
        .pg_wr_i     (pg_wr_i),
        .access_ok_o (access_ok_o),
        .mem_we_o    (mem_we_o),
        .stk_wr_ok_o (stk_wr_ok),
        .fault_o     (fault_o)
    );

    // Route an allowed stack load to the selected stack
    always_comb begin
        dsp_wr = stk_wr_ok && (sp_sel_i == STK_DATA);
        rsp_wr = stk_wr_ok && (sp_sel_i == STK_RET);
    end

    wg_stack_hi #(.ADDR_W(ADDR_W), .HI_W(DSP_HI_W)) i_dsp_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (dsp_wr),
        .data_i (sp_data_i),
        .hi_o   (dsp_hi_o)
    );

    wg_stack_hi #(.ADDR_W(ADDR_W), .HI_W(RSP_HI_W)) i_rsp_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (rsp_wr),
        .data_i (sp_data_i),
        .hi_o   (rsp_hi_o)
    );
endmodule

// File: rtl/win_guard_chk.sv
// Checker for win_guard_unit: protection and translation properties,
// watched on every cycle outside reset. Attached by bind below.
module win_guard_chk #(
    parameter int ADDR_W   = 16,
    parameter int WIN_W    = 12,
    parameter int DSP_HI_W = 8,
    parameter int RSP_HI_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       pc_i,
    input logic                    mem_req_i,
    input logic                    mem_we_i,
    input logic [ADDR_W-1:0]       mem_addr_i,
    input logic                    sp_wr_i,
    input logic                    sp_sel_i,
    input logic [ADDR_W-1:0]       sp_data_i,
    input logic                    pg_wr_i,
    input logic [ADDR_W-WIN_W-1:0] pg_data_i,
    input logic [ADDR_W-1:0]       phys_addr_o,
    input logic                    mem_we_o,
    input logic                    access_ok_o,
    input logic                    fault_o,
    input logic [DSP_HI_W-1:0]     dsp_hi_o,
    input logic [RSP_HI_W-1:0]     rsp_hi_o
);
    logic usr;
    logic out_win;

    always_comb begin
        usr     = (pc_i[ADDR_W-1:WIN_W] != '0);
        out_win = (mem_addr_i[ADDR_W-1:WIN_W] != '0);
    end

    a_r10_we_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !access_ok_o |-> !mem_we_o);

    a_r3_fault_after_stray: assert property (@(posedge clk) disable iff (!rst_n)
        (usr && mem_req_i && out_win) |=> fault_o);

    a_r9_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(usr && ((mem_req_i && out_win) || sp_wr_i || pg_wr_i)));

    a_r1_priv_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (!usr && mem_req_i) |-> (phys_addr_o == mem_addr_i && access_ok_o));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_i |-> (phys_addr_o[WIN_W-1:0] == mem_addr_i[WIN_W-1:0]));

    a_r7_stack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (usr && sp_wr_i) |=> ($stable(dsp_hi_o) && $stable(rsp_hi_o)));

    a_r6_data_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!usr && sp_wr_i && !sp_sel_i) |=>
            (dsp_hi_o == $past(sp_data_i[ADDR_W-1 -: DSP_HI_W])));

    a_r6_ret_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!usr && sp_wr_i && sp_sel_i) |=>
            (rsp_hi_o == $past(sp_data_i[ADDR_W-1 -: RSP_HI_W])));
endmodule

bind win_guard_unit win_guard_chk #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .DSP_HI_W(DSP_HI_W), .RSP_HI_W(RSP_HI_W)
) i_win_guard_chk (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .mem_req_i(mem_req_i),
    .mem_we_i(mem_we_i), .mem_addr_i(mem_addr_i), .sp_wr_i(sp_wr_i),
    .sp_sel_i(sp_sel_i), .sp_data_i(sp_data_i), .pg_wr_i(pg_wr_i),
    .pg_data_i(pg_data_i), .phys_addr_o(phys_addr_o), .mem_we_o(mem_we_o),
    .access_ok_o(access_ok_o), .fault_o(fault_o), .dsp_hi_o(dsp_hi_o),
    .rsp_hi_o(rsp_hi_o)
);

// File: tb/test_win_guard_unit.sv
// Scoreboard bench: the driver predicts each cycle's outputs into a queue,
// and the monitor compares them shortly after the driving edge.
module test_win_guard_unit;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_i = '0;
    logic        mem_req_i = 1'b0;
    logic        mem_we_i = 1'b0;
    logic [15:0] mem_addr_i = '0;
    logic        sp_wr_i = 1'b0;
    logic        sp_sel_i = 1'b0;
    logic [15:0] sp_data_i = '0;
    logic        pg_wr_i = 1'b0;
    logic [3:0]  pg_data_i = '0;
    logic [15:0] phys_addr_o;
    logic        mem_we_o;
    logic        access_ok_o;
    logic        fault_o;
    logic [7:0]  dsp_hi_o;
    logic [11:0] rsp_hi_o;

    int total = 0;
    int bad = 0;

    typedef struct {
        string       tag;
        logic [15:0] phys;
        logic        ok;
        logic        we;
        logic        fault;
        logic [7:0]  dh;
        logic [11:0] rh;
    } exp_t;

    exp_t sb[$];

    // Reference state kept from the requirements
    logic [3:0]  m_page = '0;
    logic [7:0]  m_dh = '0;
    logic [11:0] m_rh = '0;
    logic        m_prev = 1'b0;

    always #(PER/2) clk = ~clk;

    win_guard_unit i_win_guard_unit (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .mem_req_i(mem_req_i),
        .mem_we_i(mem_we_i), .mem_addr_i(mem_addr_i), .sp_wr_i(sp_wr_i),
        .sp_sel_i(sp_sel_i), .sp_data_i(sp_data_i), .pg_wr_i(pg_wr_i),
        .pg_data_i(pg_data_i), .phys_addr_o(phys_addr_o), .mem_we_o(mem_we_o),
        .access_ok_o(access_ok_o), .fault_o(fault_o), .dsp_hi_o(dsp_hi_o),
        .rsp_hi_o(rsp_hi_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and predict its outputs
    task automatic step(input string tag, input logic [15:0] pc,
                        input logic req, input logic we, input logic [15:0] addr,
                        input logic spw, input logic sel, input logic [15:0] spd,
                        input logic pgw, input logic [3:0] pgd);
        exp_t e;
        logic user;
        logic viol;
        @(negedge clk);
        pc_i = pc; mem_req_i = req; mem_we_i = we; mem_addr_i = addr;
        sp_wr_i = spw; sp_sel_i = sel; sp_data_i = spd;
        pg_wr_i = pgw; pg_data_i = pgd;
        user = (pc[15:12] != 4'h0);
        viol = user && ((req && addr[15:12] != 4'h0) || spw || pgw);
        e.tag   = tag;
        e.phys  = user ? {m_page, addr[11:0]} : addr;
        e.ok    = req && !(user && addr[15:12] != 4'h0);
        e.we    = e.ok && we;
        e.fault = m_prev;
        e.dh    = m_dh;
        e.rh    = m_rh;
        sb.push_back(e);
        if (!user && pgw) m_page = pgd;
        if (!user && spw) begin
            if (sel) m_rh = spd[15:4];
            else     m_dh = spd[15:8];
        end
        m_prev = viol;
    endtask

    // Monitor: compare each predicted cycle a quarter period after driving
    initial begin
        forever begin
            @(negedge clk);
            #(PER/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, "phys", phys_addr_o, e.phys);
                chk(e.tag, "ok", {15'd0, access_ok_o}, {15'd0, e.ok});
                chk(e.tag, "we", {15'd0, mem_we_o}, {15'd0, e.we});
                chk(e.tag, "fault", {15'd0, fault_o}, {15'd0, e.fault});
                chk(e.tag, "dsp_hi", {8'd0, dsp_hi_o}, {8'd0, e.dh});
                chk(e.tag, "rsp_hi", {4'd0, rsp_hi_o}, {4'd0, e.rh});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk("R8", "fault", {15'd0, fault_o}, 16'd0);
        chk("R8", "dsp_hi", {8'd0, dsp_hi_o}, 16'd0);
        chk("R8", "rsp_hi", {4'd0, rsp_hi_o}, 16'd0);
        rst_n = 1'b1;

        // R1: supervisor reads and writes pass untranslated
        step("R1", 16'h0100, 1, 0, 16'hABCD, 0, 0, 16'h0, 0, 4'h0);
        step("R10", 16'h0100, 1, 1, 16'h2345, 0, 0, 16'h0, 0, 4'h0);
        // R8/R2: page is 0 after reset
        step("R2", 16'h3000, 1, 0, 16'h0123, 0, 0, 16'h0, 0, 4'h0);
        // R4: supervisor at the top of its window loads the page
        step("R4", 16'h0FFF, 0, 0, 16'h0, 0, 0, 16'h0, 1, 4'hA);
        step("R2", 16'h1000, 1, 1, 16'h0FFF, 0, 0, 16'h0, 0, 4'h0);
        // R3: stray user write is gated and faults next cycle
        step("R3", 16'h1000, 1, 1, 16'h1000, 0, 0, 16'h0, 0, 4'h0);
        step("R9", 16'h1000, 0, 0, 16'h0, 0, 0, 16'h0, 0, 4'h0);
        step("R9", 16'h1000, 0, 1, 16'hFFFF, 0, 0, 16'h0, 0, 4'h0);
        // R5: user page load is refused
        step("R5", 16'h4000, 0, 0, 16'h0, 0, 0, 16'h0, 1, 4'h3);
        step("R5", 16'h4000, 1, 0, 16'h0010, 0, 0, 16'h0, 0, 4'h0);
        // R6: supervisor loads both stack upper parts
        step("R6", 16'h0000, 0, 0, 16'h0, 1, 0, 16'h5A00, 0, 4'h0);
        step("R6", 16'h0000, 0, 0, 16'h0, 1, 1, 16'h1234, 0, 4'h0);
        // R7: user stack load is refused
        step("R7", 16'h8000, 0, 0, 16'h0, 1, 0, 16'hFFFF, 0, 4'h0);
        step("R7", 16'h8000, 0, 0, 16'h0, 1, 1, 16'hFFFF, 0, 4'h0);
        // R1: supervisor high address with a nonzero page stays flat
        step("R1", 16'h0800, 1, 1, 16'hF000, 0, 0, 16'h0, 0, 4'h0);
        // R9: back-to-back violations give back-to-back fault cycles
        step("R9", 16'hF000, 1, 0, 16'h2000, 0, 0, 16'h0, 0, 4'h0);
        step("R9", 16'hF000, 1, 1, 16'hFFFF, 0, 0, 16'h0, 0, 4'h0);
        step("R9", 16'hF000, 1, 1, 16'h0FFF, 0, 0, 16'h0, 0, 4'h0);
        step("R9", 16'h0000, 0, 0, 16'h0, 0, 0, 16'h0, 0, 4'h0);
        // R4: a new supervisor page is used right away by the next user access
        step("R4", 16'h0001, 0, 0, 16'h0, 0, 0, 16'h0, 1, 4'h5);
        step("R4", 16'h2000, 1, 0, 16'h0ABC, 0, 0, 16'h0, 0, 4'h0);
        step("R10", 16'h2000, 0, 1, 16'h0ABC, 0, 0, 16'h0, 0, 4'h0);
        step("R9", 16'h0000, 0, 0, 16'h0, 0, 0, 16'h0, 0, 4'h0);
        @(negedge clk);
        #(PER/2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule